// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a 32-bit status word that records why the system last came out of reset, and lets software ask for a new system reset by writing to that word. The top five bits of the word have meaning. The power-on cause (bit 31) and the two button causes (bits 28 and 27) are sticky flags that software acknowledges by writing a one. The soft power-on bit (30) and the soft warm-reset bit (29) are request flags. Writing a one to either of them sets the flag and sends a one-cycle request to the reset controller.

A small saturating counter records how many system resets have arrived since the counter was last cleared. When a system reset arrives while the counter is zero, the word is loaded with the power-on flag alone. Every later reset leaves the word as it is, so software can see which request caused the reset. A soft power-on request clears the counter, so the next system reset is again treated as a power-on. The register sits in the upper 32-bit word of an 8-byte slot. The lower word reads as zero and ignores writes.

A separate synchronous power-up reset initialises the counter, the word and the outputs. The system reset input is the event that the block records.

Top module: `rstcause_reg`

## Requirements
- R1: While `pwr_rst` is high, the status word, the reset counter, `req_o` and `rdata` are all cleared to zero.
- R2: Write data is masked to bits 31:27. Bits 26:0 of the status word always read as zero, whatever was written to them.
- R3: Bits 31, 28 and 27 are write-one-to-clear: writing one clears the bit, and writing zero leaves it unchanged.
- R4: Bits 30 and 29 are write-one-to-set: writing one sets the bit, and no write ever clears it.
- R5: A write to the upper word with bit 30 set clears the reset counter and drives `req_o` high in the cycle after the write.
- R6: A write to the upper word with bit 29 set and bit 30 clear drives `req_o` high in the cycle after the write and leaves the counter unchanged.
- R7: On a cycle with `sys_rst` high and the counter at zero, the status word becomes 32'h8000_0000. On a cycle with `sys_rst` high and the counter nonzero, the status word keeps its value. Each `sys_rst` cycle increments the counter.
- R8: The counter stops at 2**CNT_W-1 and does not wrap. A counter that has reached this value keeps later system resets from reloading the power-on value.
- R9: Only addresses with `addr[2]`=1 reach the register. A read with `addr[2]`=0 returns zero. A write with `addr[2]`=0 changes nothing and raises no request.
- R10: A read (`rd_en` high) puts its result on `rdata` in the cycle after it is issued. `rdata` keeps that value until the next read.
- R11: A write issued in the same cycle as `sys_rst` is dropped: it raises no request and does not change the status word.
- R12: `req_o` is high for exactly one cycle for each qualifying write. In a cycle that follows no qualifying write, `req_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_rst | input | 1 | Synchronous power-up initialisation, active high |
| sys_rst | input | 1 | System reset event to be recorded, active high, one cycle per reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address within the 8-byte slot; bit 2 selects the upper word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| req_o | output | 1 | One-cycle system reset request |

## Verification
The bench sweeps every reachable starting state of the three settable flags against all 32 write patterns of the top five bits, with noise on the low bits. A design that mixes up the clear and set masks, or that lets a write clear a request bit, returns the wrong word. Counter corner cases are run as reset sequences. A counter that wraps at its limit reloads the power-on flag on a late reset. A soft warm request that clears the counter, or a soft power-on request that fails to clear it, leaves the wrong flag set after the next reset. Lower-word writes and writes that collide with a system reset are checked for silence on `req_o` and for an unchanged word.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;

  localparam int unsigned WORD_W = 32;

  // Bit positions inside the status word
  localparam int unsigned BIT_PWR_ON   = 31;
  localparam int unsigned BIT_SW_PWR   = 30;
  localparam int unsigned BIT_SW_WARM  = 29;
  localparam int unsigned BIT_BTN_PWR  = 28;
  localparam int unsigned BIT_BTN_WARM = 27;

  localparam logic [WORD_W-1:0] KEEP_MASK = 32'hF800_0000;
  localparam logic [WORD_W-1:0] CLR_MASK  = 32'h9800_0000;
  localparam logic [WORD_W-1:0] SET_MASK  = 32'h6000_0000;
  localparam logic [WORD_W-1:0] POR_WORD  = 32'h8000_0000;

  // Next status word after a write to the upper word
  function automatic logic [WORD_W-1:0] apply_write(
    input logic [WORD_W-1:0] cur,
    input logic [WORD_W-1:0] wd
  );
    logic [WORD_W-1:0] m;
    m = wd & KEEP_MASK;
    return (cur & ~(m & CLR_MASK)) | (m & SET_MASK);
  endfunction

endpackage

// File: rtl/rstcause_decode.sv
module rstcause_decode #(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              sys_rst,
  input  logic [ADDR_W-1:0] addr,
  output logic              upper_wr,
  output logic              upper_rd,
  output logic              any_rd
);

  localparam int unsigned UPPER_BIT = 2;

  logic unused_addr_bits;
  assign unused_addr_bits = ^addr;

  // Writes that collide with a system reset are dropped (R11)
  always_comb begin
    upper_wr = wr_en && addr[UPPER_BIT] && !sys_rst;
    upper_rd = rd_en && addr[UPPER_BIT];
    any_rd   = rd_en;
  end

endmodule

// File: rtl/rstcause_cnt.sv
module rstcause_cnt #(
  parameter int unsigned CNT_W = 2
) (
  input  logic clk,
  input  logic pwr_rst,
  input  logic inc,
  input  logic clr,
  output logic is_zero
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (pwr_rst) begin
      cnt_q <= '0;
    end else if (inc) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end else if (clr) begin
      cnt_q <= '0;
    end
  end

  assign is_zero = (cnt_q == '0);

  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (pwr_rst)
    (inc && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  // R5
  clr_to_zero_chk: assert property (@(posedge clk) disable iff (pwr_rst)
    (clr && !inc) |=> is_zero);

  // R7
  inc_leaves_zero_chk: assert property (@(posedge clk) disable iff (pwr_rst)
    inc |=> !is_zero);

endmodule

// File: rtl/rstcause_status.sv
module rstcause_status
  import rstcause_pkg::*;
(
  input  logic              clk,
  input  logic              pwr_rst,
  input  logic              sys_rst,
  input  logic              cnt_zero,
  input  logic              upper_wr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] status,
  output logic              cnt_clr,
  output logic              req_q
);

  logic want_req;

  always_comb begin
    cnt_clr  = upper_wr && wdata[BIT_SW_PWR];
    want_req = upper_wr && (wdata[BIT_SW_PWR] || wdata[BIT_SW_WARM]);
  end

  always_ff @(posedge clk) begin
    if (pwr_rst) begin
      status <= '0;
      req_q  <= 1'b0;
    end else begin
      req_q <= want_req;
      if (sys_rst) begin
        if (cnt_zero) status <= POR_WORD;
      end else if (upper_wr) begin
        status <= apply_write(status, wdata);
      end
    end
  end

  // R7
  por_load_chk: assert property (@(posedge clk) disable iff (pwr_rst)
    (sys_rst && cnt_zero) |=> (status == POR_WORD));

  // R7
  warm_keep_chk: assert property (@(posedge clk) disable iff (pwr_rst)
    (sys_rst && !cnt_zero) |=> $stable(status));

  // R3
  w1c_chk: assert property (@(posedge clk) disable iff (pwr_rst)
    (upper_wr && wdata[BIT_PWR_ON]) |=> !status[BIT_PWR_ON]);

  // R4
  w1s_chk: assert property (@(posedge clk) disable iff (pwr_rst)
    (upper_wr && wdata[BIT_SW_PWR]) |=> status[BIT_SW_PWR]);

  // R2
  low_zero_chk: assert property (@(posedge clk) disable iff (pwr_rst)
    (status & ~KEEP_MASK) == '0);

endmodule

// File: rtl/rstcause_reg.sv
module rstcause_reg
  import rstcause_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned CNT_W  = 2
) (
  input  logic              clk,
  input  logic              pwr_rst,
  input  logic              sys_rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              req_o
);

  logic              upper_wr, upper_rd, any_rd;
  logic              cnt_zero, cnt_clr;
  logic [WORD_W-1:0] status;

  rstcause_decode #(.ADDR_W(ADDR_W)) dec_i (
    .wr_en(wr_en), .rd_en(rd_en), .sys_rst(sys_rst), .addr(addr),
    .upper_wr(upper_wr), .upper_rd(upper_rd), .any_rd(any_rd)
  );

  rstcause_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .pwr_rst(pwr_rst), .inc(sys_rst), .clr(cnt_clr),
    .is_zero(cnt_zero)
  );

  rstcause_status stat_i (
    .clk(clk), .pwr_rst(pwr_rst), .sys_rst(sys_rst), .cnt_zero(cnt_zero),
    .upper_wr(upper_wr), .wdata(wdata), .status(status),
    .cnt_clr(cnt_clr), .req_q(req_o)
  );

  always_ff @(posedge clk) begin
    if (pwr_rst) begin
      rdata <= '0;
    end else if (any_rd) begin
      rdata <= upper_rd ? status : '0;
    end
  end

  // R12
  req_follows_write_chk: assert property (@(posedge clk) disable iff (pwr_rst)
    (wr_en && addr[2] && !sys_rst && (wdata[30] || wdata[29])) |=> req_o);

  // R12
  req_quiet_chk: assert property (@(posedge clk) disable iff (pwr_rst)
    !(wr_en && addr[2] && (wdata[30] || wdata[29])) |=> !req_o);

  // R11
  collide_drop_chk: assert property (@(posedge clk) disable iff (pwr_rst)
    sys_rst |=> !req_o);

  // R9
  lower_read_zero_chk: assert property (@(posedge clk) disable iff (pwr_rst)
    (rd_en && !addr[2]) |=> (rdata == '0));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (pwr_rst)
    !rd_en |=> $stable(rdata));

endmodule

// File: tb/rstcause_reg_tb.sv
module rstcause_reg_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 2;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic        clk = 1'b0;
  logic        pwr_rst = 1'b1;
  logic        sys_rst = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        req_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_status;
  int          m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  rstcause_reg #(.ADDR_W(3), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .pwr_rst(pwr_rst), .sys_rst(sys_rst), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .req_o(req_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic do_pwr_reset();
    @(negedge clk); pwr_rst = 1'b1;
    @(negedge clk); pwr_rst = 1'b0;
    m_status = 32'h0; m_cnt = 0;
  endtask

  task automatic do_sys_reset();
    @(negedge clk); sys_rst = 1'b1;
    @(negedge clk); sys_rst = 1'b0;
    if (m_cnt == 0) m_status = 32'h8000_0000;
    if (m_cnt < CNT_MAX) m_cnt++;
  endtask

  task automatic do_write(input string tag, input logic [2:0] a, input logic [31:0] d);
    logic [31:0] m;
    logic exp_req;
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
    exp_req = a[2] && (d[30] || d[29]);
    if (a[2]) begin
      m = d & 32'hF800_0000;
      m_status = (m_status & ~(m & 32'h9800_0000)) | (m & 32'h6000_0000);
      if (d[30]) m_cnt = 0;
    end
    check({tag, " req pulse"}, {31'h0, req_o}, {31'h0, exp_req});
    @(negedge clk);
    check({tag, " req one cycle R12"}, {31'h0, req_o}, 32'h0);
  endtask

  task automatic do_read(input string tag, input logic [2:0] a, input logic [31:0] exp);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    check(tag, rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rdata", rdata, 32'h0);
    check("R1 req", {31'h0, req_o}, 32'h0);
    pwr_rst = 1'b0; m_status = 0; m_cnt = 0;
    do_read("R1 status after pwr reset", 3'd4, 32'h0);

    // R7: first reset loads power-on word
    do_sys_reset();
    do_read("R7 first reset", 3'd4, 32'h8000_0000);
    // R3: writing zero keeps, one clears
    do_write("R3 zero write", 3'd4, 32'h0000_0000);
    do_read("R3 zero keeps", 3'd4, 32'h8000_0000);
    do_write("R3 clear", 3'd4, 32'h8000_0000);
    do_read("R3 cleared", 3'd4, 32'h0);
    // R7: second reset keeps word
    do_sys_reset();
    do_read("R7 warm keeps", 3'd4, 32'h0);

    // R9: lower word
    do_write("R9 lower write", 3'd0, 32'hFFFF_FFFF);
    do_read("R9 upper untouched", 3'd4, 32'h0);
    do_read("R9 lower reads zero", 3'd0, 32'h0);
    do_write("R9 set", 3'd4, 32'h2000_0000);
    do_read("R9 lower zero with data", 3'd3, 32'h0);

    // R10: rdata holds with no read
    repeat (3) @(negedge clk);
    check("R10 rdata hold", rdata, 32'h0);

    // R6: soft warm keeps counter, next reset does not reload
    do_sys_reset();
    do_read("R6 warm keeps counter", 3'd4, 32'h2000_0000);
    // R4: no write clears request bits
    do_write("R4 write all ones", 3'd4, 32'hFFFF_FFFF);
    do_read("R4 request bits stay", 3'd4, 32'h6000_0000);
    // R5: soft power clears counter
    do_sys_reset();
    do_read("R5 power-on after soft power", 3'd4, 32'h8000_0000);

    // R8: saturation
    do_pwr_reset();
    for (int i = 0; i < CNT_MAX + 1; i++) do_sys_reset();
    do_write("R8 clear", 3'd4, 32'h8000_0000);
    do_sys_reset();
    do_read("R8 no wrap", 3'd4, 32'h0);
    do_sys_reset();
    do_read("R8 still saturated", 3'd4, 32'h0);

    // R11: write collides with system reset
    do_pwr_reset();
    do_sys_reset();
    @(negedge clk); sys_rst = 1'b1; wr_en = 1'b1; addr = 3'd4; wdata = 32'hE000_0000;
    @(negedge clk); sys_rst = 1'b0; wr_en = 1'b0;
    m_cnt = 2;
    check("R11 no req on collision", {31'h0, req_o}, 32'h0);
    do_read("R11 word unchanged", 3'd4, 32'h8000_0000);

    // R2/R3/R4: sweep start states and write patterns
    for (int s = 0; s < 8; s++) begin
      for (int w = 0; w < 32; w++) begin
        do_pwr_reset();
        if (s[2]) do_sys_reset();
        if (s[1:0] != 2'b00) do_write("R4 setup", 3'd4, {1'b0, s[1], s[0], 29'h0});
        do_write("R2 sweep", 3'd4, {w[4:0], 27'h5A5_A5A5 ^ 27'(s * 32 + w)});
        do_read("R2 R3 R4 sweep", 3'd4, m_status);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule